// File: doc/BRIEF.md
# Return-Address and Status Stack Controller

This block keeps an eight-level stack of return frames in a byte-wide data memory that the core shares with general data. Each frame is two bytes: it holds a 13-bit program counter and three status flags (carry, auxiliary carry and register-bank select). The frames sit at data locations 8 to 23, and level n occupies bytes 8+2n and 9+2n. A push saves the frame on a call or interrupt entry. A plain return gives back only the counter. A return-and-restore gives back the counter and the three flags, and asks the core to load those flags.

The 3-bit stack pointer is kept inside the block and appears as bits 0 to 2 of the status word the block presents. The other bits of that word mirror the live flags, and bit 5 is always 1. The pointer always names the next free level. It wraps silently in both directions, so nine nested pushes overwrite level 0.

Commands use a valid/ready handshake. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` depends only on internal state, so the core may hold `cmd_valid` and its operands steady until the command is taken. Results leave as a one-cycle `res_valid` pulse with no back-pressure, and the core must consume them in that cycle. Memory reads take one cycle: `ram_rdata` shows the byte at the address driven in the previous cycle.

Top module: `retstack_top`

## Requirements
- R1: After reset, `psw_out[2:0]` is 0, `cmd_ready` is 1, and `ram_we` and `res_valid` are 0.
- R2: `psw_out` is {cy_in, ac_in, 1, bs_in, 0, sp}, with bit 7 down to bit 0 in that order. Bit 5 always reads 1 and bit 3 always reads 0.
- R3: A push (cmd_op 2'b01) writes one byte in each of the two cycles after it is taken. The first cycle writes {pc[7:0]} to address 8+2·sp. The second writes {cy, ac, bs, pc[12], pc[11:8]} to address 9+2·sp, with bit 7 first.
- R4: The pointer increments at the end of the second write cycle of a push. It wraps from 7 to 0, so a ninth nested push overwrites level 0.
- R5: A plain return (2'b10) or a return-and-restore (2'b11) decrements the pointer, modulo 8, on the edge that takes the command. It then drives address 8+2·sp in the next cycle and 9+2·sp in the cycle after. `res_valid` is high for exactly one cycle, four cycles after the command is taken, with `res_pc` equal to the saved counter.
- R6: On a return-and-restore result, `res_flag_load` is 1 and `res_cy`/`res_ac`/`res_bs` carry the saved flags. On a plain return result, `res_flag_load` is 0 and the three flag outputs are 0.
- R7: `cmd_ready` is low for the 2 cycles after a push is taken and for the 3 cycles after a return is taken. `ram_we` is high only during the push cycles.
- R8: A command with op 2'b00 is taken in one cycle and changes neither the pointer nor the memory, and it produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 00 none, 01 push, 10 return, 11 return-and-restore |
| pc_in | input | 13 | Counter value to save on a push |
| cy_in | input | 1 | Live carry flag |
| ac_in | input | 1 | Live auxiliary carry flag |
| bs_in | input | 1 | Live register-bank select |
| psw_out | output | 8 | Status word holding the stack pointer |
| res_valid | output | 1 | One-cycle result strobe |
| res_pc | output | 13 | Restored counter |
| res_cy | output | 1 | Restored carry |
| res_ac | output | 1 | Restored auxiliary carry |
| res_bs | output | 1 | Restored bank select |
| res_flag_load | output | 1 | Core should load the restored flags |
| ram_addr | output | 8 | Data-memory byte address |
| ram_we | output | 1 | Data-memory write enable |
| ram_wdata | output | 8 | Data-memory write byte |
| ram_rdata | input | 8 | Data-memory read byte, one cycle after its address |

## Verification
A wrong pointer shows up in `psw_out[2:0]` on the cycle after the command is taken, and it also shows in the addresses of the next memory access. A frame packed wrongly shows on `ram_wdata` during the two write cycles of the push. A frame unpacked wrongly only shows on the result pulse four cycles after the matching return, which can be many commands later. For that reason, random push and return sequences are checked against a model stack, including sequences that wrap past eight levels.

// File: rtl/retstack_pkg.sv
package retstack_pkg;
  localparam int PCW    = 13;
  localparam int SPW    = 3;
  localparam int LEVELS = 1 << SPW;

  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_PUSH = 2'b01,
    OP_RET  = 2'b10,
    OP_RETR = 2'b11
  } rs_op_e;

  typedef struct packed {
    logic           cy;
    logic           ac;
    logic           bs;
    logic [PCW-1:0] pc;
  } rs_frame_t;

  // upper byte: flags and PC12 in the high nibble, PC[11:8] below
  function automatic logic [15:0] rs_pack(rs_frame_t f);
    return {f.cy, f.ac, f.bs, f.pc[12], f.pc[11:8], f.pc[7:0]};
  endfunction

  function automatic rs_frame_t rs_unpack(logic [15:0] w);
    rs_frame_t f;
    f.cy = w[15];
    f.ac = w[14];
    f.bs = w[13];
    f.pc = {w[12], w[11:8], w[7:0]};
    return f;
  endfunction
endpackage

// File: rtl/retstack_ptr.sv
module retstack_ptr #(
  parameter int SPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  input  logic           dec,
  output logic [SPW-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= '0;
    else if (inc) sp <= sp + SPW'(1);
    else if (dec) sp <= sp - SPW'(1);
  end
endmodule

// File: rtl/retstack_addr.sv
module retstack_addr #(
  parameter int SPW  = 3,
  parameter int AW   = 8,
  parameter int BASE = 8
) (
  input  logic [SPW-1:0] sp,
  input  logic           hi_sel,
  output logic [AW-1:0]  addr
);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  always_comb addr = BASE_A + AW'({sp, 1'b0}) + AW'(hi_sel);
endmodule

// File: rtl/retstack_seq.sv
module retstack_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  output logic       take_push,
  output logic       take_pop,
  output logic       wr_lo,
  output logic       wr_hi,
  output logic       rd_hi,
  output logic       rd_cap,
  output logic       hi_sel,
  output logic       restore_q
);
  import retstack_pkg::*;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI, S_RCAP} st_e;
  st_e st;

  assign cmd_ready = (st == S_IDLE);
  assign take_push = cmd_valid && cmd_ready && (rs_op_e'(cmd_op) == OP_PUSH);
  assign take_pop  = cmd_valid && cmd_ready && cmd_op[1];
  assign wr_lo     = (st == S_WLO);
  assign wr_hi     = (st == S_WHI);
  assign rd_hi     = (st == S_RHI);
  assign rd_cap    = (st == S_RCAP);
  assign hi_sel    = (st == S_WHI) || (st == S_RHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      restore_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (take_push) st <= S_WLO;
          else if (take_pop) begin
            st        <= S_RLO;
            restore_q <= cmd_op[0];
          end
        end
        S_WLO:   st <= S_WHI;
        S_WHI:   st <= S_IDLE;
        S_RLO:   st <= S_RHI;
        S_RHI:   st <= S_RCAP;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/retstack_top.sv
module retstack_top #(
  parameter int AW   = 8,
  parameter int BASE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [12:0] pc_in,
  input  logic        cy_in,
  input  logic        ac_in,
  input  logic        bs_in,
  output logic [7:0]  psw_out,
  output logic        res_valid,
  output logic [12:0] res_pc,
  output logic        res_cy,
  output logic        res_ac,
  output logic        res_bs,
  output logic        res_flag_load,
  output logic [AW-1:0] ram_addr,
  output logic        ram_we,
  output logic [7:0]  ram_wdata,
  input  logic [7:0]  ram_rdata
);
  import retstack_pkg::*;

  logic take_push, take_pop, wr_lo, wr_hi, rd_hi, rd_cap, hi_sel, restore_q;
  logic [SPW-1:0] sp;
  logic [15:0] frame_w;
  logic [7:0]  lo_q;
  rs_frame_t   got;

  retstack_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .take_push(take_push), .take_pop(take_pop),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_hi(rd_hi), .rd_cap(rd_cap),
    .hi_sel(hi_sel), .restore_q(restore_q)
  );

  // pointer moves after the last write of a push, on the take edge of a pop
  retstack_ptr #(.SPW(SPW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .inc(wr_hi), .dec(take_pop), .sp(sp)
  );

  retstack_addr #(.SPW(SPW), .AW(AW), .BASE(BASE)) u_addr (
    .sp(sp), .hi_sel(hi_sel), .addr(ram_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) frame_w <= '0;
    else if (take_push) frame_w <= rs_pack('{cy: cy_in, ac: ac_in, bs: bs_in, pc: pc_in});
  end

  assign ram_we    = wr_lo || wr_hi;
  assign ram_wdata = wr_hi ? frame_w[15:8] : frame_w[7:0];
  assign psw_out   = {cy_in, ac_in, 1'b1, bs_in, 1'b0, sp};
  assign got       = rs_unpack({ram_rdata, lo_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q          <= '0;
      res_valid     <= 1'b0;
      res_pc        <= '0;
      res_cy        <= 1'b0;
      res_ac        <= 1'b0;
      res_bs        <= 1'b0;
      res_flag_load <= 1'b0;
    end else begin
      if (rd_hi) lo_q <= ram_rdata;
      res_valid <= rd_cap;
      if (rd_cap) begin
        res_pc        <= got.pc;
        res_cy        <= restore_q & got.cy;
        res_ac        <= restore_q & got.ac;
        res_bs        <= restore_q & got.bs;
        res_flag_load <= restore_q;
      end
    end
  end
endmodule

// File: rtl/retstack_chk.sv
module retstack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] psw_out,
  input logic       res_valid,
  input logic       res_cy,
  input logic       res_ac,
  input logic       res_bs,
  input logic       res_flag_load,
  input logic [7:0] ram_addr,
  input logic       ram_we
);
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    psw_out[5] && !psw_out[3]);

  a_r3_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !ram_addr[0]) |=> (ram_we && ram_addr == 8'($past(ram_addr) + 8'd1)));

  a_r4_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr[0]) |=> psw_out[2:0] == 3'($past(psw_out[2:0]) + 3'd1));

  a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op[1]) |=> psw_out[2:0] == 3'($past(psw_out[2:0]) - 3'd1));

  a_r6_plain_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_flag_load) |-> !(res_cy || res_ac || res_bs));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r7_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !cmd_ready);

  a_r8_nop_keeps_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'b00) |=> $stable(psw_out[2:0]) && cmd_ready);
endmodule

bind retstack_top retstack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .psw_out(psw_out), .res_valid(res_valid), .res_cy(res_cy),
  .res_ac(res_ac), .res_bs(res_bs), .res_flag_load(res_flag_load),
  .ram_addr(ram_addr), .ram_we(ram_we)
);

// File: tb/sim_retstack_top.sv
`timescale 1ns/1ps
module sim_retstack_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [12:0] pc_in = '0;
  logic cy_in = 1'b0, ac_in = 1'b0, bs_in = 1'b0;
  logic [7:0] psw_out;
  logic res_valid, res_cy, res_ac, res_bs, res_flag_load;
  logic [12:0] res_pc;
  logic [7:0] ram_addr, ram_wdata;
  logic ram_we;
  logic [7:0] ram_rdata = '0;
  logic [7:0] mem [256];

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [2:0]  m_sp = '0;
  logic [15:0] m_fr [8];

  always #2 clk = ~clk;

  retstack_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .pc_in(pc_in), .cy_in(cy_in), .ac_in(ac_in), .bs_in(bs_in),
    .psw_out(psw_out), .res_valid(res_valid), .res_pc(res_pc), .res_cy(res_cy),
    .res_ac(res_ac), .res_bs(res_bs), .res_flag_load(res_flag_load),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  function automatic logic [15:0] exp_frame(logic [12:0] pc, logic cy, logic ac, logic bs);
    return {cy, ac, bs, pc[12], pc[11:8], pc[7:0]};
  endfunction

  function automatic logic [7:0] exp_psw();
    return {cy_in, ac_in, 1'b1, bs_in, 1'b0, m_sp};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic do_push(logic [12:0] pc, logic cy, logic ac, logic bs);
    logic [15:0] f;
    f = exp_frame(pc, cy, ac, bs);
    wait_ready();
    cmd_valid = 1'b1; cmd_op = 2'b01; pc_in = pc; cy_in = cy; ac_in = ac; bs_in = bs;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; pc_in = ~pc;
    chk("R3 lo we", ram_we, 1);
    chk("R3 lo addr", ram_addr, 8'd8 + 8'(m_sp) * 2);
    chk("R3 lo data", ram_wdata, f[7:0]);
    chk("R7 busy push", cmd_ready, 0);
    @(negedge clk);
    chk("R3 hi addr", ram_addr, 8'd9 + 8'(m_sp) * 2);
    chk("R3 hi data", ram_wdata, f[15:8]);
    chk("R4 sp held", psw_out[2:0], m_sp);
    m_fr[m_sp] = f;
    m_sp = m_sp + 3'd1;
    @(negedge clk);
    chk("R4 sp step", psw_out, exp_psw());
    chk("R7 ready back", cmd_ready, 1);
    chk("R7 we low", ram_we, 0);
  endtask

  task automatic do_pop(logic restore);
    logic [15:0] f;
    wait_ready();
    cmd_valid = 1'b1; cmd_op = {1'b1, restore};
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    m_sp = m_sp - 3'd1;
    f = m_fr[m_sp];
    chk("R5 sp dec", psw_out[2:0], m_sp);
    chk("R5 lo addr", ram_addr, 8'd8 + 8'(m_sp) * 2);
    chk("R7 no write", ram_we, 0);
    @(negedge clk);
    chk("R5 hi addr", ram_addr, 8'd9 + 8'(m_sp) * 2);
    @(negedge clk);
    chk("R7 busy pop", cmd_ready, 0);
    chk("R5 early", res_valid, 0);
    @(negedge clk);
    chk("R5 valid", res_valid, 1);
    chk("R5 pc", res_pc, {f[12], f[11:8], f[7:0]});
    chk("R6 load", res_flag_load, restore);
    chk("R6 flags", {res_cy, res_ac, res_bs}, restore ? f[15:13] : 3'b000);
    @(negedge clk);
    chk("R7 pulse end", res_valid, 0);
  endtask

  task automatic do_nop();
    wait_ready();
    cmd_valid = 1'b1; cmd_op = 2'b00;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 sp", psw_out[2:0], m_sp);
    chk("R8 ready", cmd_ready, 1);
    chk("R8 no write", ram_we, 0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R8 no result", res_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) m_fr[i] = 16'h0000;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 psw", psw_out, 8'h20);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 we", ram_we, 0);
    chk("R1 res", res_valid, 0);
    cy_in = 1; ac_in = 0; bs_in = 1;
    @(negedge clk);
    chk("R2 psw", psw_out, 8'hB0);
    cy_in = 0; ac_in = 1; bs_in = 0;
    @(negedge clk);
    chk("R2 psw", psw_out, 8'h60);
    // directed: save and restore with flags
    do_push(13'h1ABC, 1, 0, 1);
    do_pop(1'b1);
    do_push(13'h0FFF, 1, 1, 1);
    do_pop(1'b0);
    do_nop();
    // nine nested pushes wrap and overwrite level 0
    for (int i = 0; i < 9; i++) do_push(13'(13'h100 + i * 13'h211), 1'(i), 1'(i >> 1), 1'(i >> 2));
    chk("R4 wrapped sp", psw_out[2:0], 3'd1);
    chk("R4 level0 lo", mem[8], 8'(13'h100 + 8 * 13'h211));
    for (int i = 0; i < 9; i++) do_pop(1'(i));
    // random mix
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 4) do_push(13'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      else if (r < 6) do_pop(1'b0);
      else if (r < 8) do_pop(1'b1);
      else if (r < 9) do_nop();
      else begin
        cy_in = 1'($urandom); ac_in = 1'($urandom); bs_in = 1'($urandom);
        @(negedge clk);
        chk("R2 psw rnd", psw_out, exp_psw());
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule